// File: doc/BRIEF.md
# Multi-Exit Reconfigurable Functional Unit

This block is a coarse-grain reconfigurable execution unit that runs beside a processor's integer pipeline. It holds a matrix of fixed-point functional units, four rows by four columns by default. A configuration word sets each unit's operation and its two operand sources. A unit can take an operand from a register-file input, from a shared immediate, or from any unit in an earlier row. Links that skip rows let long dependence chains fit into the matrix.

One loaded configuration describes a custom instruction that has a single entry and up to four exits, and that spans several basic blocks. Branch conditions are formed inside the matrix. Selector logic uses them to decide which exit is taken. It also decides which register results are written back, whether the single store is issued, and which target address the processor continues from.

The configuration arrives one bit at a time and is copied into an active register by a load strobe. A start pulse samples the register operands. Each matrix row is evaluated in its own cycle, and the result appears as a one-cycle completion pulse with registered outputs.

Top module: `mecu_top`

## Requirements
- R1: After reset, `cfg_ready`, `done`, `wr_en` and `st_valid` are 0 and `exit_idx` is 0. On each cycle with `cfg_shift` high, `cfg_bit` enters a staging register that shifts toward its MSB, so the first bit sent ends up in the MSB of the packed `cfg_t` word. The field order from the MSB is: unit settings (unit index NFU-1 first, each {op, srcA, srcB}); five branch-source selects (index 4 first); store-address select; store-data select; exit records (exit 3 first, each {mask, pol, st_en, we, osel[3..0], target}); four immediates (imm3 first). A `cfg_load` pulse copies the staging register into the active configuration, and `cfg_ready` is 1 from the next cycle while the unit is idle.
- R2: `start` is ignored while `cfg_ready` is 0, so no `done` follows. `cfg_load` is ignored while an instruction is running, and the running instruction and any later ones keep the old configuration.
- R3: When `start` is accepted, `cfg_ready` is 0 in the next cycle. `done` is high for exactly one cycle, in the cycle that follows the ROWS-th rising edge after the accepting edge.
- R4: Unit operation codes: 0 pass A, 1 A+B, 2 A-B, 3 AND, 4 OR, 5 XOR, 6 A shifted left by B[4:0], 7 A shifted right logically by B[4:0], 8 signed A<B giving 1 or 0, 9 A==B giving 1 or 0. Codes 10 to 15 give 0.
- R5: Source index numbering: 0 to 5 are register inputs, 6 to 9 are immediates, and 10+k is unit k, where k = row*4 + column. A unit in row r may read only units in rows below r. A select of a unit in row r or later, or any index of 26 or more, reads as 0. Branch, output and store selects may read every unit.
- R6: Branch condition b is 1 when the value at its select is nonzero. Exit e matches when every condition whose `mask` bit is set equals the matching `pol` bit. The lowest-numbered matching exit is taken. When no exit matches, exit 3 is taken.
- R7: With `done`, `exit_idx` and `exit_target` give the taken exit and its target, `wr_en` is that exit's `we`, and write lane o carries the value at that exit's `osel[o]`. `wr_en` is 0 outside `done`, and `exit_idx` and `exit_target` hold until the next `done`.
- R8: The store address and data come from the two shared store selects. `st_valid` is 1 only with `done`, and only when the taken exit has `st_en` set.
- R9: Register operands are sampled on the accepting edge. Changes on `rf_in` while the instruction runs have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_shift | input | 1 | Shift one configuration bit in |
| cfg_bit | input | 1 | Serial configuration bit |
| cfg_load | input | 1 | Copy the staged configuration into the active one |
| cfg_ready | output | 1 | A configuration is loaded and the unit is idle |
| start | input | 1 | Launch the loaded custom instruction |
| rf_in | input | 192 | Six 32-bit register operands, input 0 in the low bits |
| done | output | 1 | One-cycle completion pulse |
| exit_idx | output | 2 | Index of the taken exit |
| exit_target | output | 32 | Next program counter for the taken exit |
| wr_en | output | 4 | Per-lane register write enables |
| wr_data | output | 128 | Four 32-bit write-back values, lane 0 in the low bits |
| st_valid | output | 1 | Store request |
| st_addr | output | 32 | Store address |
| st_data | output | 32 | Store data |

## Verification
The bench targets exit priority when two exits match at once. A design with the order reversed would report the later exit and its target. The bench also covers the case where no exit matches, where a faulty default would give a stale or lower exit index. Forward and out-of-range unit selects are checked to read as zero, because a broken row limit would leak a stale result from the previous instruction into a later row. A configuration load and operand changes are driven while the unit is busy; a design that failed to block the load or to sample the operands at start would show results from the wrong configuration or operands. Completion is timed cycle by cycle, so an extra or missing pipeline stage, or a `done` lasting two cycles, is caught along with store requests issued on an exit that does not own the store.

// File: rtl/mecu_pkg.sv
package mecu_pkg;
  localparam int ROWS  = 4;
  localparam int COLS  = 4;
  localparam int NIN   = 6;
  localparam int NOUT  = 4;
  localparam int NIMM  = 4;
  localparam int NBR   = 5;
  localparam int NEXIT = 4;
  localparam int W     = 32;

  localparam int NFU   = ROWS * COLS;
  localparam int NSRC  = NIN + NIMM + NFU;
  localparam int SW    = $clog2(NSRC);
  localparam int XW    = $clog2(NEXIT);
  localparam int OPW   = 4;
  localparam int SHW   = $clog2(W);

  typedef enum logic [OPW-1:0] {
    OP_PASS = 4'd0, OP_ADD = 4'd1, OP_SUB = 4'd2, OP_AND = 4'd3,
    OP_OR   = 4'd4, OP_XOR = 4'd5, OP_SHL = 4'd6, OP_SHR = 4'd7,
    OP_SLT  = 4'd8, OP_EQ  = 4'd9
  } op_e;

  typedef struct packed {
    logic [OPW-1:0] op;
    logic [SW-1:0]  sa;
    logic [SW-1:0]  sb;
  } unit_cfg_t;

  typedef struct packed {
    logic [NBR-1:0]            mask;
    logic [NBR-1:0]            pol;
    logic                      st_en;
    logic [NOUT-1:0]           we;
    logic [NOUT-1:0][SW-1:0]   osel;
    logic [W-1:0]              target;
  } exit_cfg_t;

  typedef struct packed {
    unit_cfg_t [NFU-1:0]       fu;
    logic [NBR-1:0][SW-1:0]    bsel;
    logic [SW-1:0]             st_asel;
    logic [SW-1:0]             st_dsel;
    exit_cfg_t [NEXIT-1:0]     ex;
    logic [NIMM-1:0][W-1:0]    imm;
  } cfg_t;

  localparam int CW = $bits(cfg_t);

  // Operand source selection; units at index >= lim read as zero.
  function automatic logic [W-1:0] src_pick(
    input logic [SW-1:0]             sel,
    input logic [NIN-1:0][W-1:0]     rin,
    input logic [NIMM-1:0][W-1:0]    imm,
    input logic [NFU-1:0][W-1:0]     fuv,
    input int                        lim
  );
    logic [W-1:0] v;
    v = '0;
    for (int i = 0; i < NIN; i++)
      if (int'(sel) == i) v = rin[i];
    for (int i = 0; i < NIMM; i++)
      if (int'(sel) == NIN + i) v = imm[i];
    for (int f = 0; f < NFU; f++)
      if (f < lim && int'(sel) == NIN + NIMM + f) v = fuv[f];
    return v;
  endfunction
endpackage

// File: rtl/mecu_cfg_loader.sv
module mecu_cfg_loader #(
  parameter int CWID = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            shift_en,
  input  logic            bit_in,
  input  logic            load,
  input  logic            hold,
  output logic [CWID-1:0] act,
  output logic            valid
);
  logic [CWID-1:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      act   <= '0;
      valid <= 1'b0;
    end else begin
      if (shift_en) stage <= {stage[CWID-2:0], bit_in};
      if (load && !hold) begin
        act   <= stage;
        valid <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/mecu_fu.sv
module mecu_fu
  import mecu_pkg::*;
(
  input  logic [OPW-1:0] op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [W-1:0]   y
);
  always_comb begin
    case (op)
      OP_PASS: y = a;
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_SHL:  y = a << b[SHW-1:0];
      OP_SHR:  y = a >> b[SHW-1:0];
      OP_SLT:  y = ($signed(a) < $signed(b)) ? W'(1) : '0;
      OP_EQ:   y = (a == b) ? W'(1) : '0;
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/mecu_matrix.sv
module mecu_matrix
  import mecu_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ROWS-1:0]          row_en,
  input  logic [NIN-1:0][W-1:0]    rin,
  input  cfg_t                     cfg,
  output logic [NFU-1:0][W-1:0]    fuv
);
  logic [NFU-1:0][W-1:0] fuq;
  logic [NFU-1:0][W-1:0] ys;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int F = r * COLS + c;
      logic [W-1:0] opa, opb;
      // row r sees only units of earlier rows
      assign opa = src_pick(cfg.fu[F].sa, rin, cfg.imm, fuq, r * COLS);
      assign opb = src_pick(cfg.fu[F].sb, rin, cfg.imm, fuq, r * COLS);
      mecu_fu u_fu (.op(cfg.fu[F].op), .a(opa), .b(opb), .y(ys[F]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fuq <= '0;
    end else begin
      for (int r = 0; r < ROWS; r++)
        if (row_en[r])
          for (int c = 0; c < COLS; c++)
            fuq[r*COLS+c] <= ys[r*COLS+c];
    end
  end

  assign fuv = fuq;
endmodule

// File: rtl/mecu_exit_sel.sv
module mecu_exit_sel
  import mecu_pkg::*;
(
  input  logic [NIN-1:0][W-1:0]   rin,
  input  cfg_t                    cfg,
  input  logic [NFU-1:0][W-1:0]   fuv,
  output logic [XW-1:0]           idx,
  output logic [NOUT-1:0]         we,
  output logic [NOUT-1:0][W-1:0]  wdata,
  output logic [W-1:0]            target,
  output logic                    st_en,
  output logic [W-1:0]            st_addr,
  output logic [W-1:0]            st_data
);
  logic [NBR-1:0] cond;

  always_comb begin
    for (int b = 0; b < NBR; b++)
      cond[b] = |src_pick(cfg.bsel[b], rin, cfg.imm, fuv, NFU);
    idx = XW'(NEXIT - 1);
    // descending scan leaves the lowest matching exit
    for (int e = NEXIT - 1; e >= 0; e--)
      if (&((cond ~^ cfg.ex[e].pol) | ~cfg.ex[e].mask)) idx = XW'(e);
  end

  always_comb begin
    we      = cfg.ex[idx].we;
    target  = cfg.ex[idx].target;
    st_en   = cfg.ex[idx].st_en;
    st_addr = src_pick(cfg.st_asel, rin, cfg.imm, fuv, NFU);
    st_data = src_pick(cfg.st_dsel, rin, cfg.imm, fuv, NFU);
    for (int o = 0; o < NOUT; o++)
      wdata[o] = src_pick(cfg.ex[idx].osel[o], rin, cfg.imm, fuv, NFU);
  end
endmodule

// File: rtl/mecu_top.sv
module mecu_top
  import mecu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_shift,
  input  logic              cfg_bit,
  input  logic              cfg_load,
  output logic              cfg_ready,
  input  logic              start,
  input  logic [NIN*W-1:0]  rf_in,
  output logic              done,
  output logic [XW-1:0]     exit_idx,
  output logic [W-1:0]      exit_target,
  output logic [NOUT-1:0]   wr_en,
  output logic [NOUT*W-1:0] wr_data,
  output logic              st_valid,
  output logic [W-1:0]      st_addr,
  output logic [W-1:0]      st_data
);
  localparam int SPW = $clog2(ROWS + 1);

  logic                    busy;
  logic [SPW-1:0]          step;
  logic                    cfg_valid;
  logic [CW-1:0]           act_bits;
  cfg_t                    cfg_act;
  logic                    go;
  logic [ROWS-1:0]         row_en;
  logic [NIN-1:0][W-1:0]   rin_port, opnd_q, rin;
  logic [NFU-1:0][W-1:0]   fuv;

  logic [XW-1:0]           x_idx;
  logic [NOUT-1:0]         x_we;
  logic [NOUT-1:0][W-1:0]  x_wd;
  logic [W-1:0]            x_tgt, x_sa, x_sd;
  logic                    x_st;

  assign cfg_act   = cfg_t'(act_bits);
  assign cfg_ready = cfg_valid & ~busy;
  assign go        = start & cfg_ready;
  assign rin_port  = rf_in;
  assign rin       = busy ? opnd_q : rin_port;

  mecu_cfg_loader #(.CWID(CW)) u_ld (
    .clk(clk), .rst(rst), .shift_en(cfg_shift), .bit_in(cfg_bit),
    .load(cfg_load), .hold(busy | go), .act(act_bits), .valid(cfg_valid)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_en
    if (r == 0) begin : g_first
      assign row_en[r] = go;
    end else begin : g_rest
      assign row_en[r] = busy && (step == SPW'(r));
    end
  end

  mecu_matrix u_mx (
    .clk(clk), .rst(rst), .row_en(row_en), .rin(rin), .cfg(cfg_act), .fuv(fuv)
  );

  mecu_exit_sel u_xs (
    .rin(rin), .cfg(cfg_act), .fuv(fuv), .idx(x_idx), .we(x_we),
    .wdata(x_wd), .target(x_tgt), .st_en(x_st), .st_addr(x_sa), .st_data(x_sd)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= 1'b0;
      step        <= '0;
      opnd_q      <= '0;
      done        <= 1'b0;
      exit_idx    <= '0;
      exit_target <= '0;
      wr_en       <= '0;
      wr_data     <= '0;
      st_valid    <= 1'b0;
      st_addr     <= '0;
      st_data     <= '0;
    end else begin
      done     <= 1'b0;
      wr_en    <= '0;
      st_valid <= 1'b0;
      if (go) begin
        busy   <= 1'b1;
        step   <= SPW'(1);
        opnd_q <= rin_port;
      end else if (busy) begin
        if (step == SPW'(ROWS)) begin
          busy        <= 1'b0;
          done        <= 1'b1;
          exit_idx    <= x_idx;
          exit_target <= x_tgt;
          wr_en       <= x_we;
          wr_data     <= x_wd;
          st_valid    <= x_st;
          st_addr     <= x_sa;
          st_data     <= x_sd;
        end else begin
          step <= step + SPW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/mecu_chk.sv
module mecu_chk
  import mecu_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            start,
  input logic            cfg_ready,
  input logic            busy,
  input logic            done,
  input logic [NOUT-1:0] wr_en,
  input logic            st_valid,
  input logic [XW-1:0]   exit_idx,
  input logic [W-1:0]    exit_target,
  input logic [CW-1:0]   act_bits
);
  a_r3_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (start && cfg_ready) |=> !cfg_ready);
  a_r3_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  a_r3_done_after_busy: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(busy));
  a_r2_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(act_bits));
  a_r7_we_with_done: assert property (@(posedge clk) disable iff (rst)
    (|wr_en) |-> done);
  a_r7_exit_held: assert property (@(posedge clk) disable iff (rst)
    !($stable(exit_idx) && $stable(exit_target)) |-> done);
  a_r8_store_with_done: assert property (@(posedge clk) disable iff (rst)
    st_valid |-> done);
endmodule

bind mecu_top mecu_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .cfg_ready(cfg_ready), .busy(busy),
  .done(done), .wr_en(wr_en), .st_valid(st_valid), .exit_idx(exit_idx),
  .exit_target(exit_target), .act_bits(act_bits)
);

// File: tb/sim_mecu_top.sv
`timescale 1ns/1ps
module sim_mecu_top;
  import mecu_pkg::*;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_shift = 1'b0, cfg_bit = 1'b0, cfg_load = 1'b0, start = 1'b0;
  logic cfg_ready, done, st_valid;
  logic [NIN-1:0][W-1:0]  ops_drv = '0;
  logic [NIN*W-1:0]       rf_in;
  logic [XW-1:0]          exit_idx;
  logic [W-1:0]           exit_target, st_addr, st_data;
  logic [NOUT-1:0]        wr_en;
  logic [NOUT*W-1:0]      wr_data;
  logic [NOUT-1:0][W-1:0] wd;

  assign rf_in = ops_drv;
  assign wd    = wr_data;

  always #2 clk = ~clk;

  mecu_top u0 (
    .clk(clk), .rst(rst), .cfg_shift(cfg_shift), .cfg_bit(cfg_bit),
    .cfg_load(cfg_load), .cfg_ready(cfg_ready), .start(start), .rf_in(rf_in),
    .done(done), .exit_idx(exit_idx), .exit_target(exit_target), .wr_en(wr_en),
    .wr_data(wr_data), .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [31:0] rs;
  function automatic logic [31:0] nxt();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  function automatic logic [W-1:0] m_alu(input logic [3:0] op,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      4'd0: return a;
      4'd1: return a + b;
      4'd2: return a - b;
      4'd3: return a & b;
      4'd4: return a | b;
      4'd5: return a ^ b;
      4'd6: return a << b[4:0];
      4'd7: return a >> b[4:0];
      4'd8: return ($signed(a) < $signed(b)) ? 1 : 0;
      4'd9: return (a == b) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [W-1:0] m_pick(input logic [SW-1:0] sel,
      input logic [NIN-1:0][W-1:0] ri, input cfg_t c,
      input logic [NFU-1:0][W-1:0] fv, input int lim);
    int s;
    s = int'(sel);
    if (s < NIN) return ri[s];
    s = s - NIN;
    if (s < NIMM) return c.imm[s];
    s = s - NIMM;
    if (s < lim) return fv[s];
    return 0;
  endfunction

  logic [XW-1:0]          m_exit;
  logic [W-1:0]           m_tgt, m_sa, m_sd;
  logic [NOUT-1:0]        m_we;
  logic [NOUT-1:0][W-1:0] m_wd;
  logic                   m_st;

  task automatic model(input cfg_t c, input logic [NIN-1:0][W-1:0] ri);
    logic [NFU-1:0][W-1:0] fv;
    logic [NBR-1:0] cd;
    bit found;
    fv = '0;
    for (int r = 0; r < ROWS; r++)
      for (int k = 0; k < COLS; k++)
        fv[r*COLS+k] = m_alu(c.fu[r*COLS+k].op,
                             m_pick(c.fu[r*COLS+k].sa, ri, c, fv, r*COLS),
                             m_pick(c.fu[r*COLS+k].sb, ri, c, fv, r*COLS));
    for (int b = 0; b < NBR; b++) cd[b] = (m_pick(c.bsel[b], ri, c, fv, NFU) != 0);
    found = 0;
    m_exit = XW'(NEXIT - 1);
    for (int e = 0; e < NEXIT; e++) begin
      bit ok;
      ok = 1;
      for (int b = 0; b < NBR; b++)
        if (c.ex[e].mask[b] && (cd[b] != c.ex[e].pol[b])) ok = 0;
      if (ok && !found) begin found = 1; m_exit = XW'(e); end
    end
    m_tgt = c.ex[m_exit].target;
    m_we  = c.ex[m_exit].we;
    m_st  = c.ex[m_exit].st_en;
    m_sa  = m_pick(c.st_asel, ri, c, fv, NFU);
    m_sd  = m_pick(c.st_dsel, ri, c, fv, NFU);
    for (int o = 0; o < NOUT; o++) m_wd[o] = m_pick(c.ex[m_exit].osel[o], ri, c, fv, NFU);
  endtask

  function automatic cfg_t gen_cfg(input logic [31:0] seed);
    cfg_t c;
    int lim;
    rs = seed | 32'h1;
    for (int f = 0; f < NFU; f++) begin
      lim = NIN + NIMM + (f / COLS) * COLS;
      c.fu[f].op = 4'(nxt() % 11);
      c.fu[f].sa = (nxt() % 8 == 0) ? SW'(nxt()) : SW'(nxt() % lim);
      c.fu[f].sb = (nxt() % 8 == 0) ? SW'(nxt()) : SW'(nxt() % lim);
    end
    for (int b = 0; b < NBR; b++) c.bsel[b] = SW'(nxt() % NSRC);
    c.st_asel = SW'(nxt() % NSRC);
    c.st_dsel = SW'(nxt() % NSRC);
    for (int e = 0; e < NEXIT; e++) begin
      c.ex[e].mask   = NBR'(nxt());
      c.ex[e].pol    = NBR'(nxt());
      c.ex[e].st_en  = nxt() % 2 == 0;
      c.ex[e].we     = NOUT'(nxt());
      for (int o = 0; o < NOUT; o++) c.ex[e].osel[o] = SW'(nxt() % NSRC);
      c.ex[e].target = nxt();
    end
    for (int i = 0; i < NIMM; i++) c.imm[i] = (nxt() % 3 == 0) ? W'(nxt() % 40) : nxt();
    return c;
  endfunction

  function automatic logic [NIN-1:0][W-1:0] gen_ops(input logic [31:0] seed);
    logic [NIN-1:0][W-1:0] v;
    rs = seed | 32'h1;
    for (int i = 0; i < NIN; i++) v[i] = (nxt() % 4 == 0) ? '0 : nxt();
    return v;
  endfunction

  // ---------------- drivers ----------------
  task automatic load_cfg(input cfg_t c);
    logic [CW-1:0] bits;
    bits = c;
    for (int i = CW - 1; i >= 0; i--) begin
      @(negedge clk);
      cfg_shift = 1'b1;
      cfg_bit   = bits[i];
    end
    @(negedge clk);
    cfg_shift = 1'b0;
    cfg_load  = 1'b1;
    @(negedge clk);
    cfg_load  = 1'b0;
    chk("R1", "ready after load", cfg_ready, 1);
  endtask

  logic [XW-1:0]          cap_exit;
  logic [W-1:0]           cap_tgt, cap_sa, cap_sd;
  logic [NOUT-1:0]        cap_we;
  logic [NOUT-1:0][W-1:0] cap_wd;
  logic                   cap_st;

  task automatic run_check(input cfg_t c, input logic [NIN-1:0][W-1:0] ops,
                           input bit load_busy, input string tag);
    int seen;
    model(c, ops);
    @(negedge clk);
    start   = 1'b1;
    ops_drv = ops;
    @(negedge clk);
    start   = 1'b0;
    ops_drv = ~ops;  // R9: junk while busy
    chk("R3", "ready low after start", cfg_ready, 0);
    seen = -1;
    for (int k = 0; k <= ROWS + 1; k++) begin
      if (k > 0) @(negedge clk);
      if (load_busy && k == 1) cfg_load = 1'b1;
      if (load_busy && k == 2) cfg_load = 1'b0;
      if (done && seen < 0) seen = k;
      if (k == ROWS) begin
        cap_exit = exit_idx; cap_tgt = exit_target; cap_we = wr_en;
        cap_wd = wd; cap_st = st_valid; cap_sa = st_addr; cap_sd = st_data;
      end
      if (k == ROWS + 1) begin
        chk("R3", "done one cycle", done, 0);
        chk("R7", "wr_en cleared after done", wr_en, 0);
        chk("R8", "st_valid cleared after done", st_valid, 0);
        chk("R7", "exit held", exit_idx, cap_exit);
        chk("R1", "ready after run", cfg_ready, 1);
      end
    end
    cfg_load = 1'b0;
    chk("R3", {tag, " latency"}, seen, ROWS);
    chk("R6", {tag, " exit"}, cap_exit, m_exit);
    chk("R7", {tag, " target"}, cap_tgt, m_tgt);
    chk("R7", {tag, " wr_en"}, cap_we, m_we);
    for (int o = 0; o < NOUT; o++) chk("R4 R5 R9", {tag, " wr_data"}, cap_wd[o], m_wd[o]);
    chk("R8", {tag, " st_valid"}, cap_st, m_st);
    if (m_st) begin
      chk("R8", {tag, " st_addr"}, cap_sa, m_sa);
      chk("R8", {tag, " st_data"}, cap_sd, m_sd);
    end
  endtask

  localparam int NVEC = 10;
  localparam logic [63:0] VEC [NVEC] = '{
    64'h1234_5678_9abc_def1, 64'h0bad_cafe_0000_0011, 64'hdead_beef_1357_2468,
    64'h0000_0007_ffff_0001, 64'h4242_4242_8181_8181, 64'h0f0f_f0f0_a5a5_5a5a,
    64'h7777_1111_2222_3333, 64'h1000_0001_0000_0003, 64'h9e37_79b9_7f4a_7c15,
    64'h0123_4567_89ab_cdef
  };

  initial begin
    cfg_t c, d;
    logic [NIN-1:0][W-1:0] ops;
    int seen;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk("R1", "reset ready", cfg_ready, 0);
    chk("R1", "reset done", done, 0);
    chk("R1", "reset wr_en", wr_en, 0);
    chk("R1", "reset st_valid", st_valid, 0);
    chk("R1", "reset exit", exit_idx, 0);

    // R2: start without a configuration
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    seen = 0;
    for (int k = 0; k < ROWS + 3; k++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk("R2", "start ignored without config", seen, 0);

    // table-driven random configurations
    for (int i = 0; i < NVEC; i++) begin
      c   = gen_cfg(VEC[i][63:32]);
      ops = gen_ops(VEC[i][31:0]);
      load_cfg(c);
      run_check(c, ops, 1'b0, "vector");
    end

    // R2: load attempted while busy keeps the running configuration
    c = gen_cfg(32'h5eed_0001);
    d = gen_cfg(32'h5eed_0002);
    load_cfg(c);
    begin
      logic [CW-1:0] bits;
      bits = d;
      for (int i = CW - 1; i >= 0; i--) begin
        @(negedge clk); cfg_shift = 1'b1; cfg_bit = bits[i];
      end
      @(negedge clk); cfg_shift = 1'b0;
    end
    run_check(c, gen_ops(32'h77), 1'b1, "R2 busy-load");
    run_check(c, gen_ops(32'h78), 1'b0, "R2 config kept");

    // R5: forward and out-of-range selects read zero
    c = '0;
    c.fu[0].op = 4'd1; c.fu[0].sa = SW'(0); c.fu[0].sb = SW'(1);
    c.fu[COLS].op   = 4'd0; c.fu[COLS].sa   = SW'(NIN + NIMM + 2*COLS);
    c.fu[COLS+1].op = 4'd0; c.fu[COLS+1].sa = SW'(31);
    c.fu[COLS+2].op = 4'd0; c.fu[COLS+2].sa = SW'(NIN + NIMM);
    c.ex[0].mask = '0; c.ex[0].we = 4'b0111;
    c.ex[0].osel[0] = SW'(NIN + NIMM + COLS);
    c.ex[0].osel[1] = SW'(NIN + NIMM + COLS + 1);
    c.ex[0].osel[2] = SW'(NIN + NIMM + COLS + 2);
    load_cfg(c);
    ops = '0; ops[0] = 32'd5; ops[1] = 32'd7;
    run_check(c, ops, 1'b0, "R5 directed");
    chk("R5", "forward row reads zero", cap_wd[0], 0);
    chk("R5", "index past range reads zero", cap_wd[1], 0);
    chk("R4", "add through skip link", cap_wd[2], 12);

    // R6/R8: exit priority, fallback and store gating
    c = '0;
    c.bsel[0] = SW'(0); c.bsel[1] = SW'(1);
    c.st_asel = SW'(1); c.st_dsel = SW'(NIN);
    c.imm[0] = 32'hABCD;
    for (int e = 0; e < NEXIT; e++) c.ex[e].target = W'(32'h100 * (e + 1));
    c.ex[0].mask = 5'b00001; c.ex[0].pol = 5'b00001;
    c.ex[1].mask = 5'b00010; c.ex[1].pol = 5'b00010; c.ex[1].st_en = 1'b1;
    c.ex[2].mask = 5'b00000;
    c.ex[3].mask = 5'b00001; c.ex[3].pol = 5'b00001;
    load_cfg(c);
    ops = '0; ops[1] = 32'd9;
    run_check(c, ops, 1'b0, "R6 priority");
    chk("R6", "lowest matching exit", cap_exit, 1);
    chk("R7", "exit 1 target", cap_tgt, 32'h200);
    chk("R8", "store on owning exit", cap_st, 1);
    chk("R8", "store address", cap_sa, 9);
    chk("R8", "store data", cap_sd, 32'hABCD);
    c.ex[2].mask = 5'b00001; c.ex[2].pol = 5'b00001;
    c.ex[1].pol  = 5'b00000;
    load_cfg(c);
    run_check(c, ops, 1'b0, "R6 fallback");
    chk("R6", "no match takes exit 3", cap_exit, 3);
    chk("R7", "exit 3 target", cap_tgt, 32'h400);
    chk("R8", "no store on exit 3", cap_st, 0);

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not finish actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule